// File: doc/BRIEF.md
# Bulk List Round-Robin Pointer

This block keeps the pointer to the endpoint descriptor currently being worked on in a linked bulk list. The list is walked in round-robin order: each time the descriptor engine finishes serving a descriptor, it hands over that descriptor's next-link, and the pointer moves there. The pointer carries over from one frame to the next, so work resumes where it stopped. When the walk reaches the end of the list, the pointer is reloaded from a head register, but only if software has raised a list-filled flag. That flag is cleared in the same update that uses it.

Software can write the head register at any time. It can write the current pointer only while the list is disabled. Both registers always read back their present value. Descriptors are 16-byte aligned: the four low bits are never stored and always read as zero. A pointer value of zero marks end of list. The link handover is a valid/ready stream whose ready output is always high, so the engine is never held back. Every update is registered and shows on the outputs one clock after the inputs that cause it.

Top module: `bulk_rr_ptr`

## Requirements
- R1: After reset, the current pointer, the head pointer and the filled flag are all zero, and end-of-list reads 1.
- R2: A handover (srv_valid=1 while list_en=1) whose link has a nonzero value in bits 31..4 sets the current pointer to that link with bits 3..0 forced to zero, one clock later. srv_ready is always 1.
- R3: A handover whose link is zero in bits 31..4, made while the flag is clear, sets the current pointer to zero and leaves the flag clear.
- R4: An end-of-list event made while the flag is set copies the head pointer into the current pointer and clears the flag in that same update.
- R5: proc_req=1 while list_en=1, with no handover and the current pointer at zero, is an end-of-list event. With the flag clear it changes nothing. proc_req has no effect while the current pointer is nonzero.
- R6: A software write with sw_sel=0 loads the current pointer only while list_en=0. While list_en=1 the write is ignored.
- R7: Bits 3..0 of both pointers always read as zero, whatever value was written.
- R8: If fill_set arrives in the same cycle that an end-of-list event uses the flag, the reload still happens and the flag ends up set.
- R9: While list_en=0, handovers and proc_req change neither the pointer nor the flag.
- R10: A software write with sw_sel=1 loads the head pointer whatever the state of list_en. Both pointers are output continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_en | input | 1 | Bulk list enable |
| srv_valid | input | 1 | Descriptor served, link valid |
| srv_ready | output | 1 | Always 1 |
| srv_link | input | 32 | Next-descriptor link of the served descriptor |
| proc_req | input | 1 | Processing requested at the current pointer |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | Write target: 0 current, 1 head |
| sw_wdata | input | 32 | Software write data |
| fill_set | input | 1 | Software set of the list-filled flag |
| cur_ptr | output | 32 | Current descriptor pointer |
| head_ptr | output | 32 | Head descriptor pointer |
| fill_flag | output | 1 | List-filled flag |
| end_of_list | output | 1 | Current pointer is zero |

## Verification
The walk is tried with three kinds of link:
- a plain nonzero link, which checks the advance;
- a link whose only nonzero bits are the reserved ones, which shows that end of list is decided on bits 31..4 alone;
- a zero link, tried both with the flag clear and with it set, which separates the stop case from the reload case.

The idle request at a zero pointer is tried with the flag clear and with it set. A set that lands on the same cycle as a reload shows that the new request is not lost. Software writes and handovers are each repeated with the list enabled and with it disabled. This shows that the enable gates software only in one state and hardware only in the other.

// File: rtl/bulk_rr_pkg.sv
package bulk_rr_pkg;
  localparam int PTR_W   = 32;
  localparam int ALIGN_W = 4;

  typedef enum logic {
    SEL_CUR  = 1'b0,
    SEL_HEAD = 1'b1
  } sw_sel_e;
endpackage

// File: rtl/bulk_aligned_reg.sv
module bulk_aligned_reg #(
  parameter int W     = 32,
  parameter int ALIGN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int SW = W - ALIGN;

  logic [SW-1:0] store;

  always_ff @(posedge clk) begin
    if (!rst_n)  store <= '0;
    else if (ld) store <= d[W-1:ALIGN];
  end

  generate
    if (ALIGN > 0) begin : g_pad
      assign q = {store, {ALIGN{1'b0}}};
    end else begin : g_nopad
      assign q = store;
    end
  endgenerate
endmodule

// File: rtl/bulk_eol_ctrl.sv
module bulk_eol_ctrl #(
  parameter int W     = 32,
  parameter int ALIGN = 4
) (
  input  logic         list_en,
  input  logic         srv_valid,
  input  logic [W-1:0] srv_link,
  input  logic         proc_req,
  input  logic         cur_zero,
  input  logic         fill,
  output logic         srv_evt,
  output logic         eol_evt,
  output logic         consume
);
  logic link_zero;
  logic idle_eol;

  assign link_zero = (srv_link[W-1:ALIGN] == '0);
  assign srv_evt   = list_en & srv_valid;
  assign idle_eol  = list_en & proc_req & ~srv_valid & cur_zero;
  assign eol_evt   = (srv_evt & link_zero) | idle_eol;
  assign consume   = eol_evt & fill;
endmodule

// File: rtl/bulk_fill_flag.sv
module bulk_fill_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= (q & ~clr) | set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q); // R4
endmodule

// File: rtl/bulk_rr_ptr.sv
module bulk_rr_ptr
  import bulk_rr_pkg::*;
#(
  parameter int W     = PTR_W,
  parameter int ALIGN = ALIGN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         list_en,
  input  logic         srv_valid,
  output logic         srv_ready,
  input  logic [W-1:0] srv_link,
  input  logic         proc_req,
  input  logic         sw_wr,
  input  logic         sw_sel,
  input  logic [W-1:0] sw_wdata,
  input  logic         fill_set,
  output logic [W-1:0] cur_ptr,
  output logic [W-1:0] head_ptr,
  output logic         fill_flag,
  output logic         end_of_list
);
  logic         srv_evt, eol_evt, consume;
  logic         cur_zero;
  logic         sw_cur, sw_head;
  logic         cur_ld;
  logic [W-1:0] cur_d;

  assign srv_ready   = 1'b1;
  assign cur_zero    = (cur_ptr == '0);
  assign end_of_list = cur_zero;
  assign sw_cur      = sw_wr & (sw_sel_e'(sw_sel) == SEL_CUR);
  assign sw_head     = sw_wr & (sw_sel_e'(sw_sel) == SEL_HEAD);

  bulk_eol_ctrl #(.W(W), .ALIGN(ALIGN)) u_eol (
    .list_en   (list_en),
    .srv_valid (srv_valid),
    .srv_link  (srv_link),
    .proc_req  (proc_req),
    .cur_zero  (cur_zero),
    .fill      (fill_flag),
    .srv_evt   (srv_evt),
    .eol_evt   (eol_evt),
    .consume   (consume)
  );

  // The head pointer is written directly; current pointer takes a priority mux
  always_comb begin
    cur_ld = 1'b1;
    cur_d  = cur_ptr;
    if (consume)                 cur_d = head_ptr;
    else if (srv_evt)            cur_d = srv_link;
    else if (sw_cur && !list_en) cur_d = sw_wdata;
    else                         cur_ld = 1'b0;
  end

  bulk_aligned_reg #(.W(W), .ALIGN(ALIGN)) u_cur (
    .clk (clk), .rst_n (rst_n), .ld (cur_ld), .d (cur_d), .q (cur_ptr)
  );

  bulk_aligned_reg #(.W(W), .ALIGN(ALIGN)) u_head (
    .clk (clk), .rst_n (rst_n), .ld (sw_head), .d (sw_wdata), .q (head_ptr)
  );

  bulk_fill_flag u_fill (
    .clk (clk), .rst_n (rst_n), .set (fill_set), .clr (consume), .q (fill_flag)
  );

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (list_en && srv_valid && srv_link[W-1:ALIGN] != '0)
      |=> cur_ptr[W-1:ALIGN] == $past(srv_link[W-1:ALIGN])); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (list_en && fill_flag && ((srv_valid && srv_link[W-1:ALIGN] == '0) ||
                              (!srv_valid && proc_req && cur_ptr == '0)))
      |=> cur_ptr == $past(head_ptr)); // R4
  AST_SW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (list_en && sw_wr && !sw_sel && !srv_valid && !proc_req)
      |=> $stable(cur_ptr)); // R6
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!list_en && !(sw_wr && !sw_sel)) |=> $stable(cur_ptr)); // R9
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ptr[ALIGN-1:0] == '0) && (head_ptr[ALIGN-1:0] == '0)); // R7
endmodule

// File: tb/bulk_rr_ptr_test.sv
module bulk_rr_ptr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        list_en, srv_valid, srv_ready, proc_req, sw_wr, sw_sel, fill_set;
  logic [31:0] srv_link, sw_wdata, cur_ptr, head_ptr;
  logic        fill_flag, end_of_list;
  int          n_run = 0, n_fail = 0;
  logic [31:0] head_val;

  always #4 clk = ~clk;

  bulk_rr_ptr uut (
    .clk (clk), .rst_n (rst_n), .list_en (list_en),
    .srv_valid (srv_valid), .srv_ready (srv_ready), .srv_link (srv_link),
    .proc_req (proc_req), .sw_wr (sw_wr), .sw_sel (sw_sel),
    .sw_wdata (sw_wdata), .fill_set (fill_set), .cur_ptr (cur_ptr),
    .head_ptr (head_ptr), .fill_flag (fill_flag), .end_of_list (end_of_list)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    srv_valid = 0; srv_link = '0; proc_req = 0;
    sw_wr = 0; sw_sel = 0; sw_wdata = '0; fill_set = 0;
  endtask

  // finish the cycle's stimulus: cross one posedge, then sample at negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic serve(logic [31:0] link);
    srv_valid = 1; srv_link = link; step();
  endtask

  task automatic sw_write(logic sel, logic [31:0] d);
    sw_wr = 1; sw_sel = sel; sw_wdata = d; step();
  endtask

  task automatic raise_fill();
    fill_set = 1; step();
  endtask

  task automatic t_reset();
    check("R1 cur", cur_ptr, 32'h0);
    check("R1 head", head_ptr, 32'h0);
    check("R1 fill", {31'd0, fill_flag}, 32'd0);
    check("R1 eol", {31'd0, end_of_list}, 32'd1);
    check("R2 ready", {31'd0, srv_ready}, 32'd1);
  endtask

  task automatic t_head();
    list_en = 1;
    sw_write(1'b1, 32'h1000_0A5F);
    head_val = 32'h1000_0A50;
    check("R10 head write enabled", head_ptr, head_val);
    check("R7 head low bits", {28'd0, head_ptr[3:0]}, 32'd0);
  endtask

  task automatic t_sw_gate();
    list_en = 0;
    sw_write(1'b0, 32'h2000_0123);
    check("R6 write disabled", cur_ptr, 32'h2000_0120);
    check("R7 cur low bits", {28'd0, cur_ptr[3:0]}, 32'd0);
    list_en = 1;
    sw_write(1'b0, 32'h3000_0000);
    check("R6 write ignored", cur_ptr, 32'h2000_0120);
  endtask

  task automatic t_advance();
    serve(32'h4444_4448);
    check("R2 advance a", cur_ptr, 32'h4444_4440);
    serve(32'h5555_5550);
    check("R2 advance b", cur_ptr, 32'h5555_5550);
    check("R2 not eol", {31'd0, end_of_list}, 32'd0);
    proc_req = 1; step();
    check("R5 req nonzero ptr", cur_ptr, 32'h5555_5550);
  endtask

  task automatic t_eol_noflag();
    serve(32'h0000_000C);
    check("R3 ptr zero", cur_ptr, 32'h0);
    check("R3 flag clear", {31'd0, fill_flag}, 32'd0);
    check("R3 eol", {31'd0, end_of_list}, 32'd1);
  endtask

  task automatic t_idle_req();
    proc_req = 1; step();
    check("R5 no flag stays", cur_ptr, 32'h0);
    raise_fill();
    check("R5 flag set", {31'd0, fill_flag}, 32'd1);
    proc_req = 1; step();
    check("R5 reload", cur_ptr, head_val);
    check("R4 flag consumed idle", {31'd0, fill_flag}, 32'd0);
  endtask

  task automatic t_eol_reload();
    serve(32'h7777_7770);
    raise_fill();
    serve(32'h0);
    check("R4 reload", cur_ptr, head_val);
    check("R4 flag cleared", {31'd0, fill_flag}, 32'd0);
  endtask

  task automatic t_collide();
    serve(32'h7777_7770);
    raise_fill();
    srv_valid = 1; srv_link = '0; fill_set = 1; step();
    check("R8 reload", cur_ptr, head_val);
    check("R8 flag kept", {31'd0, fill_flag}, 32'd1);
    serve(32'h0);
    check("R8 later consume", {31'd0, fill_flag}, 32'd0);
  endtask

  task automatic t_disabled();
    serve(32'h1234_5670);
    raise_fill();
    list_en = 0;
    serve(32'h6000_0000);
    check("R9 link ignored", cur_ptr, 32'h1234_5670);
    serve(32'h0);
    check("R9 eol ignored ptr", cur_ptr, 32'h1234_5670);
    check("R9 eol ignored flag", {31'd0, fill_flag}, 32'd1);
    sw_write(1'b1, 32'h0BAD_0000);
    check("R10 head write disabled", head_ptr, 32'h0BAD_0000);
    list_en = 1;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); list_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_head();
    t_sw_gate();
    t_advance();
    t_eol_noflag();
    t_idle_req();
    t_eol_reload();
    t_collide();
    t_disabled();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule